// File: doc/BRIEF.md
# OOB Metadata Rotator and Packer

This block moves the four bytes of per-sector system metadata between a host-side spare-area byte image and the word-oriented spare buffer used by a flash controller. Every ECC step covers 1024 data bytes and owns one 4-byte metadata slot. The slots do not move straight across. Controller step 0 carries the metadata of the last step. Every later controller step i carries the slot of step i-1. This rotation frees the first spare word of each page for boot-loader use while keeping the host's bad-block byte intact.

A run starts with a one-cycle start request. The direction, step count, ECC byte count and layout mode are captured at that moment. The block then handles one step per clock. In the write direction it reads four host bytes and writes one 32-bit buffer word. In the read direction it reads one buffer word and writes four host bytes. A single-cycle done pulse follows the last step. Buffer words are placed either densely, with word i for step i, or at a fixed stride. That stride is 128 bytes (32 words) when the ECC byte count per step exceeds 60, and 64 bytes (16 words) otherwise. A blank write fills the buffer words with all-ones instead of host data.

Both memory ports read combinationally and write on the rising clock edge. The host port carries four bytes side by side: lane j, at bits 8j+7:8j, is the byte at address hostAddr+j.

Top module: `oob_meta_rotator`

## Requirements
- R1: In the write direction (dirWrite=1), controller step i writes the host slot at byte offset 4*s, where s = N-1 for i=0 and s = i-1 otherwise, and N is the step count.
- R2: In the read direction (dirWrite=0), the buffer word of controller step i is written back to the host slot at byte offset 4*s, using the same s as in R1. This is the exact inverse of R1.
- R3: Packing is little-endian. The host byte at slot offset j (j=0..3) maps to word bits 8j+7:8j, so byte 0 sits in bits 7:0 and byte 3 in bits 31:24.
- R4: With compactMode=1, step i uses buffer word i, whatever the ECC byte count.
- R5: With compactMode=0 and eccBytes > 60, step i uses word 32*i. Words between the strided slots are not written.
- R6: With compactMode=0 and eccBytes <= 60, step i uses word 16*i. The value 60 itself selects the 16-word stride.
- R7: A write with blankFill=1 writes 32'hFFFF_FFFF to every step's word and never writes the host image.
- R8: A run with step count N (1..16) keeps busy high for exactly N cycles and performs one memory write per cycle. done is high for exactly one cycle, in the cycle after the last step.
- R9: A start request that arrives while busy is high is ignored. The run neither restarts nor lengthens.
- R10: Direction, step count, ECC byte count, layout mode and blank mode are sampled only at start. Changing them during a run has no effect on that run.
- R11: After reset, busy, done, hostWe and bufWe are all low, and no write occurs while the block is idle.
- R12: With N=1, step 0 maps onto host slot 0 and buffer word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a run |
| dirWrite | input | 1 | 1: host image to buffer; 0: buffer to host image |
| blankFill | input | 1 | Write direction only: store all-ones words |
| compactMode | input | 1 | 1: dense word layout; 0: strided layout |
| eccBytes | input | 8 | ECC bytes per step; picks the stride in strided layout |
| stepCount | input | 5 | Number of ECC steps, 1 to 16 |
| busy | output | 1 | High while steps are being processed |
| done | output | 1 | One-cycle pulse after the last step |
| hostAddr | output | 6 | Byte address of the host metadata slot |
| hostRdata | input | 32 | Four host bytes starting at hostAddr, lane j = byte j |
| hostWe | output | 1 | Host image write strobe |
| hostWdata | output | 32 | Four host bytes to write, lane j = byte j |
| bufAddr | output | 9 | Word address in the spare buffer |
| bufRdata | input | 32 | Buffer word read at bufAddr |
| bufWe | output | 1 | Buffer write strobe |
| bufWdata | output | 32 | Buffer word to write |

## Verification
A corrupted step index or a wrong saved last-step value shows up at once in hostAddr or bufAddr. On the next edge it lands as a word in the wrong slot, which the per-slot comparison after each run exposes. A bad stride selection writes over sentinel words that lie between the legal strided slots. A faulty length or start-capture register changes the busy cycle count or the captured mode, and is seen at the done pulse of that same run. The run with a start request in mid-flight and configuration changes during the run aims at capture done at the wrong time.

// File: rtl/oob_rot_pkg.sv
package oob_rot_pkg;

  parameter int MAX_STEPS  = 16;
  parameter int META_BYTES = 4;
  localparam int STEP_W    = $clog2(MAX_STEPS);
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);
  localparam int WORD_W    = 8 * META_BYTES;

  typedef enum logic [1:0] {
    STRIDE_COMPACT = 2'd0,
    STRIDE_NARROW  = 2'd1,
    STRIDE_WIDE    = 2'd2
  } strideSel_t;

  // Strobes and step context from control to datapath
  typedef struct packed {
    logic              stepValid;
    logic              writeDir;
    logic              blank;
    strideSel_t        stride;
    logic [STEP_W-1:0] stepIdx;
    logic [STEP_W-1:0] lastIdx;
  } stepCmd_t;

endpackage

// File: rtl/oob_rot_ctrl.sv
module oob_rot_ctrl
  import oob_rot_pkg::*;
#(
  parameter int ECC_W     = 8,
  parameter int ECC_LIMIT = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             dirWrite,
  input  logic             blankFill,
  input  logic             compactMode,
  input  logic [ECC_W-1:0] eccBytes,
  input  logic [CNT_W-1:0] stepCount,
  output stepCmd_t         cmd,
  output logic             busy,
  output logic             done
);

  logic              runActive;
  logic              doneReg;
  logic              dirReg;
  logic              blankReg;
  strideSel_t        strideReg;
  logic [STEP_W-1:0] idxReg;
  logic [STEP_W-1:0] lastReg;
  strideSel_t        strideNext;
  logic [CNT_W-1:0]  lastCalc;

  always_comb begin
    if (compactMode)
      strideNext = STRIDE_COMPACT;
    else if (eccBytes > ECC_W'(ECC_LIMIT))
      strideNext = STRIDE_WIDE;
    else
      strideNext = STRIDE_NARROW;
    lastCalc = stepCount - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runActive <= 1'b0;
      doneReg   <= 1'b0;
      dirReg    <= 1'b0;
      blankReg  <= 1'b0;
      strideReg <= STRIDE_COMPACT;
      idxReg    <= '0;
      lastReg   <= '0;
    end else begin
      doneReg <= 1'b0;
      if (!runActive) begin
        if (startReq) begin
          runActive <= 1'b1;
          dirReg    <= dirWrite;
          blankReg  <= blankFill & dirWrite;
          strideReg <= strideNext;
          idxReg    <= '0;
          lastReg   <= lastCalc[STEP_W-1:0];
        end
      end else if (idxReg == lastReg) begin
        runActive <= 1'b0;
        doneReg   <= 1'b1;
      end else begin
        idxReg <= idxReg + STEP_W'(1);
      end
    end
  end

  always_comb begin
    cmd.stepValid = runActive;
    cmd.writeDir  = dirReg;
    cmd.blank     = blankReg;
    cmd.stride    = strideReg;
    cmd.stepIdx   = idxReg;
    cmd.lastIdx   = lastReg;
  end

  assign busy = runActive;
  assign done = doneReg;

endmodule

// File: rtl/oob_rot_dp.sv
module oob_rot_dp
  import oob_rot_pkg::*;
#(
  parameter int WIDE_STRIDE   = 128,
  parameter int NARROW_STRIDE = 64,
  parameter int HOST_AW       = STEP_W + $clog2(META_BYTES),
  parameter int BUF_AW        = $clog2((MAX_STEPS - 1) * (WIDE_STRIDE / META_BYTES) + 1)
) (
  input  stepCmd_t           cmd,
  input  logic [WORD_W-1:0]  hostRdata,
  input  logic [WORD_W-1:0]  bufRdata,
  output logic [HOST_AW-1:0] hostAddr,
  output logic               hostWe,
  output logic [WORD_W-1:0]  hostWdata,
  output logic [BUF_AW-1:0]  bufAddr,
  output logic               bufWe,
  output logic [WORD_W-1:0]  bufWdata
);

  localparam logic [BUF_AW-1:0]  WIDE_WORDS   = BUF_AW'(WIDE_STRIDE / META_BYTES);
  localparam logic [BUF_AW-1:0]  NARROW_WORDS = BUF_AW'(NARROW_STRIDE / META_BYTES);
  localparam logic [HOST_AW-1:0] SLOT_BYTES   = HOST_AW'(META_BYTES);

  logic [STEP_W-1:0] srcSlot;
  logic [WORD_W-1:0] packedWord;
  logic [WORD_W-1:0] unpackedBytes;

  // One-step rotation: controller step 0 owns the last host slot
  always_comb begin
    if (cmd.stepIdx == '0)
      srcSlot = cmd.lastIdx;
    else
      srcSlot = cmd.stepIdx - STEP_W'(1);
  end

  assign hostAddr = HOST_AW'(srcSlot) * SLOT_BYTES;

  always_comb begin
    unique case (cmd.stride)
      STRIDE_WIDE:   bufAddr = BUF_AW'(cmd.stepIdx) * WIDE_WORDS;
      STRIDE_NARROW: bufAddr = BUF_AW'(cmd.stepIdx) * NARROW_WORDS;
      default:       bufAddr = BUF_AW'(cmd.stepIdx);
    endcase
  end

  // Little-endian lane placement: host byte j <-> word bits 8j+7:8j
  for (genvar lane = 0; lane < META_BYTES; lane++) begin : g_lane
    assign packedWord[8*lane +: 8]    = hostRdata[8*lane +: 8];
    assign unpackedBytes[8*lane +: 8] = bufRdata[8*lane +: 8];
  end

  assign bufWe     = cmd.stepValid & cmd.writeDir;
  assign bufWdata  = cmd.blank ? '1 : packedWord;
  assign hostWe    = cmd.stepValid & ~cmd.writeDir;
  assign hostWdata = unpackedBytes;

endmodule

// File: rtl/oob_meta_rotator.sv
module oob_meta_rotator
  import oob_rot_pkg::*;
#(
  parameter int ECC_W         = 8,
  parameter int ECC_LIMIT     = 60,
  parameter int WIDE_STRIDE   = 128,
  parameter int NARROW_STRIDE = 64,
  parameter int HOST_AW       = STEP_W + $clog2(META_BYTES),
  parameter int BUF_AW        = $clog2((MAX_STEPS - 1) * (WIDE_STRIDE / META_BYTES) + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               dirWrite,
  input  logic               blankFill,
  input  logic               compactMode,
  input  logic [ECC_W-1:0]   eccBytes,
  input  logic [CNT_W-1:0]   stepCount,
  output logic               busy,
  output logic               done,
  output logic [HOST_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0]  hostRdata,
  output logic               hostWe,
  output logic [WORD_W-1:0]  hostWdata,
  output logic [BUF_AW-1:0]  bufAddr,
  input  logic [WORD_W-1:0]  bufRdata,
  output logic               bufWe,
  output logic [WORD_W-1:0]  bufWdata
);

  stepCmd_t cmd;

  oob_rot_ctrl #(
    .ECC_W     (ECC_W),
    .ECC_LIMIT (ECC_LIMIT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .dirWrite    (dirWrite),
    .blankFill   (blankFill),
    .compactMode (compactMode),
    .eccBytes    (eccBytes),
    .stepCount   (stepCount),
    .cmd         (cmd),
    .busy        (busy),
    .done        (done)
  );

  oob_rot_dp #(
    .WIDE_STRIDE   (WIDE_STRIDE),
    .NARROW_STRIDE (NARROW_STRIDE),
    .HOST_AW       (HOST_AW),
    .BUF_AW        (BUF_AW)
  ) u_dp (
    .cmd       (cmd),
    .hostRdata (hostRdata),
    .bufRdata  (bufRdata),
    .hostAddr  (hostAddr),
    .hostWe    (hostWe),
    .hostWdata (hostWdata),
    .bufAddr   (bufAddr),
    .bufWe     (bufWe),
    .bufWdata  (bufWdata)
  );

endmodule

// File: rtl/oob_rot_checker.sv
module oob_rot_checker
  import oob_rot_pkg::*;
#(
  parameter int HOST_AW = 6,
  parameter int BUF_AW  = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic               busy,
  input logic               done,
  input logic               hostWe,
  input logic               bufWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [BUF_AW-1:0]  bufAddr,
  input stepCmd_t           cmd
);

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a run ends with done in the following cycle
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: steps advance by exactly one per cycle
  a_r8_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmd.stepIdx != cmd.lastIdx) |=> (busy && cmd.stepIdx == $past(cmd.stepIdx) + STEP_W'(1)));

  // R9: a start during a run does not restart the step sequence
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && cmd.stepIdx != cmd.lastIdx) |=> (cmd.stepIdx != '0));

  // R11: no memory write while idle, never both directions at once
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!hostWe && !bufWe));
  a_r11_one_dir: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostWe, bufWe}));

  // R4: every layout places step 0 at word 0; R1: step 0 reads the last slot
  a_r4_first_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (bufAddr == '0));
  a_r1_first_slot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (hostAddr == HOST_AW'(cmd.lastIdx) * HOST_AW'(META_BYTES)));

endmodule

bind oob_meta_rotator oob_rot_checker #(
  .HOST_AW (HOST_AW),
  .BUF_AW  (BUF_AW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .done     (done),
  .hostWe   (hostWe),
  .bufWe    (bufWe),
  .hostAddr (hostAddr),
  .bufAddr  (bufAddr),
  .cmd      (cmd)
);

// File: tb/oob_meta_rotator_tb.sv
module oob_meta_rotator_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        dirWrite = 1'b0;
  logic        blankFill = 1'b0;
  logic        compactMode = 1'b0;
  logic [7:0]  eccBytes = 8'd0;
  logic [4:0]  stepCount = 5'd1;
  logic        busy, done, hostWe, bufWe;
  logic [5:0]  hostAddr;
  logic [8:0]  bufAddr;
  logic [31:0] hostRdata, hostWdata, bufRdata, bufWdata;

  logic [7:0]  hostMem  [64];
  logic [31:0] bufMem   [512];
  logic [7:0]  hostSnap [64];
  logic [31:0] bufSnap  [512];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  oob_meta_rotator u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dirWrite(dirWrite),
    .blankFill(blankFill), .compactMode(compactMode), .eccBytes(eccBytes),
    .stepCount(stepCount), .busy(busy), .done(done), .hostAddr(hostAddr),
    .hostRdata(hostRdata), .hostWe(hostWe), .hostWdata(hostWdata),
    .bufAddr(bufAddr), .bufRdata(bufRdata), .bufWe(bufWe), .bufWdata(bufWdata)
  );

  assign hostRdata = {hostMem[hostAddr + 3], hostMem[hostAddr + 2],
                      hostMem[hostAddr + 1], hostMem[hostAddr]};
  assign bufRdata  = bufMem[bufAddr];

  always @(posedge clk) begin
    if (hostWe)
      for (int j = 0; j < 4; j++) hostMem[hostAddr + j] <= hostWdata[8*j +: 8];
    if (bufWe)
      bufMem[bufAddr] <= bufWdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wordOf(input int i, input bit compact, input int ecc);
    if (compact) return i;
    return (ecc > 60) ? i * 32 : i * 16;
  endfunction

  function automatic int slotOf(input int i, input int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  task automatic seedMems(input int seed);
    for (int k = 0; k < 64; k++) hostMem[k] = 8'(seed * 7 + k * 13 + 1);
    for (int w = 0; w < 512; w++) bufMem[w] = {8'(seed), 8'hA5, 16'(w)};
    for (int k = 0; k < 64; k++) hostSnap[k] = hostMem[k];
    for (int w = 0; w < 512; w++) bufSnap[w] = bufMem[w];
  endtask

  function automatic logic [31:0] snapSlot(input int s);
    return {hostSnap[4*s+3], hostSnap[4*s+2], hostSnap[4*s+1], hostSnap[4*s]};
  endfunction

  function automatic logic [31:0] hostSlot(input int s);
    return {hostMem[4*s+3], hostMem[4*s+2], hostMem[4*s+1], hostMem[4*s]};
  endfunction

  // Starts a run and waits for done; returns the number of busy cycles
  task automatic runOp(input bit wr, input int n, input int ecc, input bit compact,
                       input bit blank, input bit poke, output int cyc);
    int guard;
    @(negedge clk);
    dirWrite = wr; stepCount = 5'(n); eccBytes = 8'(ecc);
    compactMode = compact; blankFill = blank; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) cyc++;
      if (poke && cyc == 2) begin
        // R9/R10: mid-run start and changed configuration
        startReq = 1'b1; dirWrite = ~wr; eccBytes = 8'd5;
        compactMode = ~compact; blankFill = ~blank; stepCount = 5'd16;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    startReq = 1'b0;
    check("R8 done reached", 32'(done), 32'd1);
    @(negedge clk);
    check("R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic checkWrite(input string req, input int n, input int ecc, input bit compact);
    for (int i = 0; i < n; i++)
      check(req, bufMem[wordOf(i, compact, ecc)], snapSlot(slotOf(i, n)));
  endtask

  task automatic checkRead(input string req, input int n, input int ecc, input bit compact);
    for (int i = 0; i < n; i++)
      check(req, hostSlot(slotOf(i, n)), bufSnap[wordOf(i, compact, ecc)]);
  endtask

  task automatic t_reset;
    check("R11 busy after reset", 32'(busy), 32'd0);
    check("R11 done after reset", 32'(done), 32'd0);
    check("R11 no writes idle", 32'({hostWe, bufWe}), 32'd0);
  endtask

  task automatic t_write_wide;
    int cyc;
    seedMems(1);
    runOp(1'b1, 4, 61, 1'b0, 1'b0, 1'b0, cyc);
    check("R8 busy cycles", cyc, 4);
    checkWrite("R1 R5 wide write", 4, 61, 1'b0);
    check("R3 byte order", bufMem[0], {hostSnap[15], hostSnap[14], hostSnap[13], hostSnap[12]});
    check("R5 gap untouched", bufMem[16], bufSnap[16]);
    check("R5 gap untouched", bufMem[1], bufSnap[1]);
  endtask

  task automatic t_write_narrow;
    int cyc;
    seedMems(2);
    runOp(1'b1, 8, 60, 1'b0, 1'b0, 1'b0, cyc);
    check("R8 busy cycles", cyc, 8);
    checkWrite("R6 narrow write at 60", 8, 60, 1'b0);
    check("R6 gap untouched", bufMem[32 * 5], bufSnap[32 * 5]);
  endtask

  task automatic t_write_compact;
    int cyc;
    seedMems(3);
    runOp(1'b1, 16, 100, 1'b1, 1'b0, 1'b0, cyc);
    check("R8 busy cycles", cyc, 16);
    checkWrite("R4 compact write", 16, 100, 1'b1);
    check("R4 past end untouched", bufMem[16], bufSnap[16]);
  endtask

  task automatic t_read_wide;
    int cyc;
    seedMems(4);
    runOp(1'b0, 5, 61, 1'b0, 1'b0, 1'b0, cyc);
    check("R8 busy cycles", cyc, 5);
    checkRead("R2 R3 wide read", 5, 61, 1'b0);
    check("R2 slot beyond N untouched", hostSlot(5), snapSlot(5));
  endtask

  task automatic t_read_compact;
    int cyc;
    seedMems(5);
    runOp(1'b0, 3, 20, 1'b1, 1'b0, 1'b0, cyc);
    checkRead("R2 R4 compact read", 3, 20, 1'b1);
    check("R2 first slot from word 1", hostSlot(0), bufSnap[1]);
  endtask

  task automatic t_blank;
    int cyc;
    seedMems(6);
    runOp(1'b1, 2, 61, 1'b0, 1'b1, 1'b0, cyc);
    check("R7 blank word 0", bufMem[0], 32'hFFFF_FFFF);
    check("R7 blank word 1", bufMem[32], 32'hFFFF_FFFF);
    check("R7 host untouched", hostSlot(1), snapSlot(1));
  endtask

  task automatic t_single;
    int cyc;
    seedMems(7);
    runOp(1'b1, 1, 61, 1'b0, 1'b0, 1'b0, cyc);
    check("R12 single busy cycle", cyc, 1);
    check("R12 single step", bufMem[0], snapSlot(0));
    check("R12 next word untouched", bufMem[32], bufSnap[32]);
  endtask

  task automatic t_busy_start;
    int cyc;
    seedMems(8);
    runOp(1'b1, 4, 61, 1'b0, 1'b0, 1'b1, cyc);
    check("R9 no lengthened run", cyc, 4);
    checkWrite("R10 config held", 4, 61, 1'b0);
    check("R10 host untouched", hostSlot(0), snapSlot(0));
    check("R9 idle after run", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seedMems(0);
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_wide();
    t_write_narrow();
    t_write_compact();
    t_read_wide();
    t_read_compact();
    t_blank();
    t_single();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule